// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer that software services through a single 32-bit control word. Each write to the word carries a start count, a command bit that both runs the counter and arms the key check, and a 7-bit key. After the watchdog has been armed, a write is accepted only if its key is the bitwise inverse of the key held from the last accepted write. Writes that fail this check are dropped completely, so a runaway program that keeps writing the same value cannot keep the watchdog alive.

The counter counts down on a slow tick-enable input, nominally close to 760 Hz. When it first runs out, the block raises a non-maskable interrupt and restarts itself with a short grace count. If the grace count also runs out before software makes an accepted write, the block asserts a system-reset request. That request stays high until the block itself is reset. The circuit that performs the reset lies outside this block.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the stored control word is 0, `nmi` and `sys_rst_req` are low, the counter is stopped, and the first write is accepted whatever its key.
- R2: While the stored bit 8 is 1, a write is accepted only if its key field wr_data[15:9] equals the bitwise inverse of the stored key. Any other write changes nothing.
- R3: An accepted write loads the counter from wr_data[CNT_W-1:0]. A value of 0 loads 2^CNT_W, which is 256 at the default width.
- R4: An accepted write with bit 8 equal to 1 runs the counter. With bit 8 equal to 0 it stops the counter, and a stopped counter ignores ticks.
- R5: An accepted write lowers `nmi` in the next cycle and clears the expiry history. A later expiry then counts as a first expiry again.
- R6: The first expiry happens on the tick that takes the count from 1 to 0. It raises `nmi` and reloads the counter with GRACE, and the counter keeps running.
- R7: An expiry that comes after an earlier expiry, with no accepted write between them, raises `sys_rst_req`.
- R8: Once `sys_rst_req` is high it stays high until reset, even across accepted writes.
- R9: The count changes only in cycles where `tick_en` is high or a write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | One-cycle pulse that marks a slow count step |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word: count in the low bits, run/arm in bit 8, key in [15:9] |
| nmi | output | 1 | Non-maskable interrupt raised on the first expiry |
| sys_rst_req | output | 1 | System-reset request, held until reset |

## Verification
The bench builds the block with CNT_W=4 and GRACE=3. At this size every start value from 0 to 15, including the 0-means-16 case, can be run through its full first and second expiry in a few dozen ticks each. The 7-bit key is swept over all 128 values against a raised warning, so exactly one key is expected to lower `nmi`. Cycle timing and field positions stay the same as in the default build.

// File: rtl/wd_pkg.sv
package wd_pkg;
  localparam int WD_WORD_W = 32;
  localparam int WD_RUN_BIT = 8;
  localparam int WD_KEY_LO = 9;
  localparam int WD_KEY_W = 7;
  localparam int WD_KEY_HI = WD_KEY_LO + WD_KEY_W - 1;

  typedef logic [WD_KEY_W-1:0] wd_key_t;

  function automatic wd_key_t key_field(input logic [WD_WORD_W-1:0] w);
    return w[WD_KEY_HI:WD_KEY_LO];
  endfunction
endpackage

// File: rtl/wd_key_gate.sv
module wd_key_gate
  import wd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [WD_WORD_W-1:0] wr_data,
  output logic                 accept,
  output logic [WD_WORD_W-1:0] ctrl_q
);
  logic [WD_WORD_W-1:0] ctrl_d;
  logic                 armed;
  logic                 key_ok;

  always_comb begin
    armed  = ctrl_q[WD_RUN_BIT];
    key_ok = (key_field(wr_data) == ~key_field(ctrl_q));
    accept = wr_en & (~armed | key_ok);
    ctrl_d = accept ? wr_data : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/wd_down_counter.sv
module wd_down_counter #(
  parameter int CNT_W = 8,
  parameter int GRACE = 10,
  localparam int CW = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             load_run,
  output logic [CW-1:0]    cnt_q,
  output logic             run_q,
  output logic             expire
);
  localparam logic [CW-1:0] GRACE_V = CW'(GRACE);
  localparam logic [CW-1:0] FULL_V  = CW'(1) << CNT_W;

  logic [CW-1:0] cnt_d;
  logic          run_d;
  logic [CW-1:0] load_cnt;
  logic          step;

  always_comb begin
    load_cnt = (load_val == '0) ? FULL_V : {1'b0, load_val};
    step     = tick_en & run_q & ~load;
    expire   = step & (cnt_q == CW'(1));
    cnt_d    = cnt_q;
    run_d    = run_q;
    if (load) begin
      cnt_d = load_cnt;
      run_d = load_run;
    end else if (expire) begin
      cnt_d = GRACE_V;
    end else if (step) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end
endmodule

// File: rtl/wd_stage.sv
module wd_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic expire,
  output logic nmi_q,
  output logic rst_req_q
);
  logic nmi_d;
  logic rst_req_d;

  always_comb begin
    nmi_d     = nmi_q;
    rst_req_d = rst_req_q;
    if (clear) begin
      nmi_d = 1'b0;
    end else if (expire) begin
      if (nmi_q) rst_req_d = 1'b1;
      else       nmi_d     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      nmi_q     <= nmi_d;
      rst_req_q <= rst_req_d;
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wd_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int GRACE = 10,
  localparam int CW = CNT_W + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic        nmi,
  output logic        sys_rst_req
);
  logic [1:0]           rst_sync_q;
  logic                 rst_sync_n;
  logic                 accept;
  logic [WD_WORD_W-1:0] ctrl_q;
  logic [CW-1:0]        cnt_q;
  logic                 run_q;
  logic                 expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  wd_key_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .accept  (accept),
    .ctrl_q  (ctrl_q)
  );

  wd_down_counter #(.CNT_W(CNT_W), .GRACE(GRACE)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick_en  (tick_en),
    .load     (accept),
    .load_val (wr_data[CNT_W-1:0]),
    .load_run (wr_data[WD_RUN_BIT]),
    .cnt_q    (cnt_q),
    .run_q    (run_q),
    .expire   (expire)
  );

  wd_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clear     (accept),
    .expire    (expire),
    .nmi_q     (nmi),
    .rst_req_q (sys_rst_req)
  );
endmodule

// File: rtl/wd_checker.sv
module wd_checker
  import wd_pkg::*;
#(
  parameter int CW = 9
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick_en,
  input logic                 wr_en,
  input logic [WD_WORD_W-1:0] wr_data,
  input logic                 accept,
  input logic [WD_WORD_W-1:0] ctrl_q,
  input logic [CW-1:0]        cnt_q,
  input logic                 run_q,
  input logic                 nmi,
  input logic                 sys_rst_req
);
  // R2
  key_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ctrl_q[WD_RUN_BIT] && (key_field(wr_data) != ~key_field(ctrl_q)))
      |=> $stable(ctrl_q));

  // R5
  nmi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !nmi);

  // R6
  nmi_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi) |-> $past(tick_en) && $past(run_q));

  // R7
  rst_after_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> $past(nmi));

  // R8
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> sys_rst_req);

  // R9
  no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !accept) |=> $stable(cnt_q));

  // R4
  stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !accept) |=> $stable(cnt_q) && !$rose(nmi));
endmodule

bind keyed_watchdog wd_checker #(.CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .tick_en     (tick_en),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .accept      (accept),
  .ctrl_q      (ctrl_q),
  .cnt_q       (cnt_q),
  .run_q       (run_q),
  .nmi         (nmi),
  .sys_rst_req (sys_rst_req)
);

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
  localparam int CNT_W = 4;
  localparam int GRACE = 3;
  localparam int LIMIT = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        nmi;
  logic        sys_rst_req;

  int n_run = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  keyed_watchdog #(.CNT_W(CNT_W), .GRACE(GRACE)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_data(wr_data), .nmi(nmi), .sys_rst_req(sys_rst_req)
  );

  function automatic logic [31:0] mk(input logic [6:0] key, input logic run, input int cnt);
    return {16'h0, key, run, 8'(cnt)};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  initial begin
    for (int c = 0; c < LIMIT; c++) @(posedge clk);
    if (!done) begin
      n_run++; n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    logic [6:0] k;
    do_reset();
    // R1 reset state
    check("R1 nmi", nmi, 0);
    check("R1 rst_req", sys_rst_req, 0);

    // R3 R6 R7 R8: every start value, first write after reset with arbitrary key (R1)
    for (int s = 0; s < 16; s++) begin
      int n;
      n = (s == 0) ? 16 : s;
      k = 7'(s * 9 + 5);
      do_reset();
      wr(mk(k, 1'b1, s));
      tick(n - 1);
      check("R3 no early nmi", nmi, 0);
      tick(1);
      check("R6 nmi at expiry", nmi, 1);
      check("R6 no rst at first expiry", sys_rst_req, 0);
      tick(GRACE - 1);
      check("R6 grace not elapsed", sys_rst_req, 0);
      tick(1);
      check("R7 rst after grace", sys_rst_req, 1);
      wr(mk(~k, 1'b1, 5));
      check("R5 nmi cleared", nmi, 0);
      check("R8 rst held after write", sys_rst_req, 1);
      tick(12);
      check("R8 rst held", sys_rst_req, 1);
    end

    // R2 sweep of all keys against a raised warning; only inverse key accepted
    k = 7'h2A;
    for (int c = 0; c < 128; c++) begin
      logic [6:0] cc;
      cc = 7'(c);
      do_reset();
      wr(mk(k, 1'b1, 2));
      tick(2);
      wr(mk(cc, 1'b1, 2));
      check("R2 key sweep nmi", nmi, (cc == ~k) ? 0 : 1);
    end

    // R2 key chain: inverse of the newly stored key is required next
    do_reset();
    wr(mk(k, 1'b1, 4));
    wr(mk(~k, 1'b1, 4));
    tick(4);
    check("R2 chain nmi raised", nmi, 1);
    wr(mk(~k, 1'b1, 4));
    check("R2 stale key ignored", nmi, 1);
    wr(mk(k, 1'b1, 4));
    check("R2 chained key accepted", nmi, 0);

    // R4 stop command, ticks ignored; key check disarmed
    do_reset();
    wr(mk(k, 1'b0, 3));
    tick(20);
    check("R4 stopped no nmi", nmi, 0);
    wr(mk(7'h55, 1'b1, 2));
    tick(2);
    check("R4 disarmed write accepted", nmi, 1);

    // R5 history cleared: next expiry is a first expiry again
    do_reset();
    wr(mk(k, 1'b1, 3));
    tick(3);
    check("R5 nmi up", nmi, 1);
    wr(mk(~k, 1'b1, 3));
    check("R5 nmi down", nmi, 0);
    tick(3);
    check("R5 second warning", nmi, 1);
    check("R5 no rst", sys_rst_req, 0);

    // R9 count moves only on ticks
    do_reset();
    wr(mk(k, 1'b1, 1));
    repeat (50) @(negedge clk);
    check("R9 idle no nmi", nmi, 0);
    tick(1);
    check("R9 tick expires", nmi, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule